// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block is the column counter inside a synchronous DRAM device. When a read or write column command arrives, it takes the starting column and the burst settings: the order bit and the three-bit length code. From the next clock on, it produces one column address per cycle, together with a valid flag. It marks the final beat of a finite burst, and it reports a one-cycle error pulse when the command carries a length or order setting that is not allowed.

Sequential bursts count upward within the aligned block of the burst size, and the upper column bits are held. Interleaved bursts XOR the beat index into the low bits of the starting column. A full-page sequential burst walks through the whole 512-column row, wraps at the top, and runs until it is cut off. Any new column command replaces a running burst on the next clock, and commands may arrive back-to-back. A stop command ends the burst at once.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `col_valid`, `burst_last` and `mode_err` are 0 and `col_out` is 0.
- R2: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. `col_valid` is high for exactly that many consecutive cycles when nothing interrupts the burst.
- R3: With `cmd_ilv`=0 (sequential), beat i has the upper column bits of the start column, and its low log2(BL) bits equal the start's low bits plus i, modulo BL.
- R4: With `cmd_ilv`=1 (interleave), beat i is the start column with its low log2(BL) bits XORed with i.
- R5: The first beat appears on the cycle after an accepted `cmd_go`, and `col_out` equals `cmd_col` on that beat.
- R6: Code 111 with `cmd_ilv`=0 is a full-page burst. The column increments by one each cycle, wraps from 511 to 0, and `burst_last` never rises.
- R7: Codes 100, 101 and 110, and code 111 with `cmd_ilv`=1, are reserved. Such a `cmd_go` raises `mode_err` for one cycle, on the next cycle, and starts no burst. A burst already running continues unchanged.
- R8: `burst_last` is high only on the final beat of a finite burst.
- R9: An accepted `cmd_go` during a burst replaces it on the next cycle. Commands on consecutive clocks are each accepted.
- R10: `cmd_halt` without an accepted `cmd_go` drops `col_valid` on the next cycle, and the output stays idle until a new command. A halt while idle has no effect. When `cmd_go` and `cmd_halt` arrive together, `cmd_go` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_go | input | 1 | Column command (read or write) this cycle |
| cmd_col | input | 9 | Starting column of the command |
| cmd_ilv | input | 1 | Burst order: 0 sequential, 1 interleave |
| cmd_len | input | 3 | Burst length code |
| cmd_halt | input | 1 | Burst stop command |
| col_out | output | 9 | Current column address |
| col_valid | output | 1 | `col_out` carries a burst beat |
| burst_last | output | 1 | Final beat of a finite burst |
| mode_err | output | 1 | Previous command used a reserved setting |

## Verification
A corrupted beat counter or base register appears at once as a wrong `col_out` on the very next beat, and the bench compares the address on every valid cycle. A wrong length mask shows up as `burst_last` on the wrong beat, or as a burst that ends early or late. A stuck run flag shows up as `col_valid` lingering one or more cycles past a halt or past the final beat. Random traffic, with frequent interrupts and reserved codes, reaches mid-burst replacement and wrap states within a few cycles.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam int unsigned MAX_BL_LOG2 = 3;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_ILV = 1'b1
  } burst_order_e;

  localparam logic [LEN_CODE_W-1:0] LEN_FULL_PAGE = 3'b111;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  burst_order_e          order,
  output logic [COL_W-1:0]      len_mask,
  output logic                  full_page,
  output logic                  legal
);
  localparam int unsigned FIN_CODES = MAX_BL_LOG2 + 1;

  logic [COL_W-1:0] fin_mask;

  always_comb begin
    fin_mask = '0;
    for (int unsigned k = 0; k < FIN_CODES; k++) begin
      if (len_code == LEN_CODE_W'(k)) fin_mask = COL_W'((1 << k) - 1);
    end
  end

  always_comb begin
    full_page = (len_code == LEN_FULL_PAGE) && (order == ORDER_SEQ);
    legal     = full_page || (int'(len_code) < int'(FIN_CODES));
    len_mask  = full_page ? '1 : fin_mask;
  end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] step,
  input  logic [COL_W-1:0] len_mask,
  input  burst_order_e     order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + step;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!len_mask[b])            col[b] = base[b];
      else if (order == ORDER_ILV) col[b] = base[b] ^ step[b];
      else                         col[b] = sum[b];
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [COL_W-1:0] start_col,
  input  burst_order_e     order_in,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             legal_in,
  input  logic             halt,
  output logic [COL_W-1:0] col_q,
  output logic             run_q,
  output logic             last_q,
  output logic             err_q
);
  logic [COL_W-1:0] base_q, step_q, mask_q, step_nx, calc_col;
  logic             full_q;
  burst_order_e     order_q;
  logic             accept;

  assign accept  = go && legal_in;
  assign step_nx = step_q + 1'b1;

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base     (base_q),
    .step     (step_nx),
    .len_mask (mask_q),
    .order    (order_q),
    .col      (calc_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      step_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      order_q <= ORDER_SEQ;
      col_q   <= '0;
      run_q   <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= go && !legal_in;
      if (accept) begin
        base_q  <= start_col;
        step_q  <= '0;
        mask_q  <= mask_in;
        full_q  <= full_in;
        order_q <= order_in;
        col_q   <= start_col;
        run_q   <= 1'b1;
        last_q  <= !full_in && (mask_in == '0);
      end else if (halt) begin
        run_q  <= 1'b0;
        last_q <= 1'b0;
      end else if (run_q && !last_q) begin
        step_q <= step_nx;
        col_q  <= calc_col;
        last_q <= !full_q && (step_nx == mask_q);
      end else begin
        run_q  <= 1'b0;
        last_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_go,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_ilv,
  input  logic [2:0]       cmd_len,
  input  logic             cmd_halt,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             burst_last,
  output logic             mode_err
);
  burst_order_e     order;
  logic [COL_W-1:0] dec_mask;
  logic             dec_full, dec_legal;

  assign order = burst_order_e'(cmd_ilv);

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code  (cmd_len),
    .order     (order),
    .len_mask  (dec_mask),
    .full_page (dec_full),
    .legal     (dec_legal)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (cmd_go),
    .start_col (cmd_col),
    .order_in  (order),
    .mask_in   (dec_mask),
    .full_in   (dec_full),
    .legal_in  (dec_legal),
    .halt      (cmd_halt),
    .col_q     (col_out),
    .run_q     (col_valid),
    .last_q    (burst_last),
    .err_q     (mode_err)
  );
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_go,
  input logic [COL_W-1:0] cmd_col,
  input logic             cmd_ilv,
  input logic [2:0]       cmd_len,
  input logic             cmd_halt,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             burst_last,
  input logic             mode_err
);
  logic ok_mode;
  assign ok_mode = !cmd_len[2] || (cmd_len == 3'b111 && !cmd_ilv);

  // R5
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && ok_mode) |=> (col_valid && col_out == $past(cmd_col)));

  // R7
  reserved_err_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && !ok_mode) |=> mode_err);

  // R7
  err_only_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && ok_mode) |=> !mode_err);

  // R8
  last_is_beat_chk: assert property (@(posedge clk) disable iff (rst)
    burst_last |-> col_valid);

  // R8
  last_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_last && !(cmd_go && ok_mode)) |=> !col_valid);

  // R10
  halt_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_halt && !(cmd_go && ok_mode)) |=> !col_valid);
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_go     (cmd_go),
  .cmd_col    (cmd_col),
  .cmd_ilv    (cmd_ilv),
  .cmd_len    (cmd_len),
  .cmd_halt   (cmd_halt),
  .col_out    (col_out),
  .col_valid  (col_valid),
  .burst_last (burst_last),
  .mode_err   (mode_err)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_go = 1'b0, cmd_ilv = 1'b0, cmd_halt = 1'b0;
  logic [8:0] cmd_col = '0;
  logic [2:0] cmd_len = '0;
  logic [8:0] col_out;
  logic       col_valid, burst_last, mode_err;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  bit m_valid, m_done, m_err, m_full, m_ilv;
  int m_start, m_i, m_bl, m_col;

  always #10 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_col(cmd_col), .cmd_ilv(cmd_ilv),
    .cmd_len(cmd_len), .cmd_halt(cmd_halt), .col_out(col_out),
    .col_valid(col_valid), .burst_last(burst_last), .mode_err(mode_err)
  );

  function automatic int exp_col(int start, int i, int bl, bit ilv);
    int mask = bl - 1;
    if (ilv) return start ^ i;
    return (start & ~mask & 511) | ((start + i) & mask);
  endfunction

  function automatic bit mode_ok(bit ilv, int len);
    return (len < 4) || (len == 7 && !ilv);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (col_valid !== m_valid || burst_last !== m_done || mode_err !== m_err ||
        (m_valid && col_out !== 9'(m_col))) begin
      failures++;
      $display("FAIL %s: got v=%0b c=%0d l=%0b e=%0b exp v=%0b c=%0d l=%0b e=%0b",
               tag, col_valid, col_out, burst_last, mode_err,
               m_valid, m_col, m_done, m_err);
    end
  endtask

  task automatic cyc(bit go, int col, bit ilv, int len, bit halt, string tag);
    bit ok;
    @(negedge clk);
    cmd_go = go; cmd_col = 9'(col); cmd_ilv = ilv; cmd_len = 3'(len); cmd_halt = halt;
    @(posedge clk);
    #1;
    ok = mode_ok(ilv, len);
    m_err = go && !ok;
    if (go && ok) begin
      m_start = col; m_i = 0; m_full = (len == 7); m_bl = m_full ? 512 : (1 << len);
      m_ilv = ilv; m_valid = 1; m_col = col; m_done = !m_full && m_bl == 1;
    end else if (halt) begin
      m_valid = 0; m_done = 0;
    end else if (m_valid && !m_done) begin
      m_i = (m_i + 1) % 512;
      m_col = exp_col(m_start, m_i, m_bl, m_ilv);
      m_done = !m_full && (m_i == m_bl - 1);
    end else begin
      m_valid = 0; m_done = 0;
    end
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: got cycles=%0d exp done", cycles);
        finish_run();
      end
    end
  end

  initial begin
    bit g, il, h;
    int ln;
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    m_valid = 0; m_done = 0; m_err = 0; m_col = 0;
    compare("R1 in reset");
    checks++;
    if (col_out !== 9'd0) begin
      failures++;
      $display("FAIL R1: got col=%0d exp 0", col_out);
    end
    @(negedge clk); rst = 0;
    idle(2, "R1 after reset");

    // R2 R3 sequential lengths
    for (int l = 0; l < 4; l++) begin
      cyc(1, 13, 0, l, 0, "R2 R3 R5 seq start");
      idle(9, "R2 R3 R8 seq beats");
    end
    // R4 interleave lengths
    for (int l = 0; l < 4; l++) begin
      cyc(1, 13, 1, l, 0, "R4 R5 ilv start");
      idle(9, "R4 R8 ilv beats");
    end
    // R6 full page wrap
    cyc(1, 508, 0, 7, 0, "R6 full page start");
    idle(12, "R6 full page wrap");
    // R10 halt
    cyc(0, 0, 0, 0, 1, "R10 halt");
    idle(3, "R10 after halt");
    cyc(0, 0, 0, 0, 1, "R10 halt idle");
    cyc(1, 100, 0, 3, 1, "R10 go beats halt");
    idle(9, "R10 burst continues");
    // R7 reserved codes
    cyc(1, 5, 0, 4, 0, "R7 code 100");
    cyc(1, 5, 1, 5, 0, "R7 code 101");
    cyc(1, 5, 0, 6, 0, "R7 code 110");
    cyc(1, 5, 1, 7, 0, "R7 full ilv");
    idle(2, "R7 idle");
    cyc(1, 40, 0, 3, 0, "R7 burst");
    idle(2, "R7 burst");
    cyc(1, 77, 1, 7, 0, "R7 reserved mid burst");
    idle(7, "R7 burst unchanged");
    // R9 interrupt and back-to-back
    cyc(1, 200, 0, 3, 0, "R9 first");
    idle(2, "R9 beats");
    cyc(1, 301, 1, 2, 0, "R9 interrupt");
    cyc(1, 400, 0, 1, 0, "R9 back to back");
    cyc(1, 7, 0, 0, 0, "R9 back to back");
    idle(4, "R9 tail");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      g  = ($urandom % 6) == 0;
      h  = ($urandom % 15) == 0;
      il = $urandom % 2;
      ln = $urandom % 8;
      cyc(g, $urandom % 512, il, ln, h, "random R3 R4 R6 R9");
    end
    idle(12, "random tail");
    finish_run();
  end
endmodule